// File: doc/BRIEF.md
# Serial link rate fallback controller

This block chooses the transmit signalling rate for one port of a serial link. With automatic discovery enabled it starts at the fastest rate in the port's supported-rate mask. It compares the rate seen on the receiver with the rate it is sending, and lowers its own rate one supported step at a time until the two match and symbol lock is reported. The link therefore settles at the fastest rate both ends share, not at a fixed common floor.

The same step-down path serves error recovery. When recovery is triggered on a running link, the controller first waits for symbol lock at the unchanged rate. It falls to the next lower supported rate only if a programmable lock window runs out. Software can turn automatic discovery off and write the rate directly. It can also abort training and restart it. A failure to train raises a sticky flag that stays set until software restarts training.

Rate codes are 0 = 1.25, 1 = 2.5, 2 = 3.125, 3 = 5.0 and 4 = 6.25 GBaud. Mask bit i set means code i is supported. Codes 5 to 7 are never supported.

Top module: `rate_fallback_ctrl`

## Requirements
- R1: While `rst_n` is low, `tx_rate` is 0 and `rate_chg_done`, `link_up`, `training` and `train_fail` are all 0.
- R2: With `auto_en` high and the controller idle, the next clock edge starts training at the highest code whose bit is set in `sup_mask` (bit i = code i). `training` goes high. If the mask is empty, training fails instead (R6).
- R3: While training, a valid detected receive rate lower than `tx_rate` moves `tx_rate` at the next edge to the highest supported code below it, skipping unsupported codes, and restarts the lock window.
- R4: While training, `sym_lock` high together with a valid receive rate equal to `tx_rate` makes `link_up` high at the next edge, with the rate unchanged.
- R5: A training attempt at one rate that sees neither a lower receive rate nor a match stays at that rate for `lock_limit`+1 cycles and then steps down as in R3.
- R6: A step-down with no lower supported code makes `train_fail` high and `training` low, keeps `tx_rate`, and holds `train_fail` until a restart.
- R7: `err_recov` on a linked port enters recovery at the same rate (`training` high, `link_up` low). `sym_lock` during recovery returns to linked without a rate change.
- R8: If recovery sees no `sym_lock` for `lock_limit`+1 cycles, the rate steps down as in R3 and training continues.
- R9: `sw_abort` during training or recovery ends it at the next edge with `train_fail` high and `training` low.
- R10: `sw_restart` in the failed state clears `train_fail` and returns to idle, and training then starts again from the top (R2). In any other state `sw_restart` has no effect.
- R11: With `auto_en` low, `tx_rate` follows `sw_rate` at the next edge when that code is supported. An unsupported `sw_rate` leaves `tx_rate` unchanged. `link_up` and `training` are low in this mode.
- R12: `rate_chg_done` is high for exactly those cycles in which `tx_rate` differs from its value in the previous cycle.
- R13: Every rate the controller selects has its bit set in `sup_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_mask | input | 5 | Supported rate codes, bit i = code i |
| auto_en | input | 1 | Automatic rate discovery enable |
| sw_rate | input | 3 | Software rate code used when `auto_en` is low |
| sw_abort | input | 1 | Abort training or recovery |
| sw_restart | input | 1 | Leave the failed state and retrain |
| rx_rate_vld | input | 1 | `rx_rate` is valid |
| rx_rate | input | 3 | Rate code detected on the receiver |
| sym_lock | input | 1 | Receiver has symbol lock |
| err_recov | input | 1 | Enter error recovery |
| lock_limit | input | 16 | Lock window length minus one, in cycles |
| tx_rate | output | 3 | Selected transmit rate code |
| rate_chg_done | output | 1 | Pulse in the cycle `tx_rate` takes a new value |
| link_up | output | 1 | Link trained and running |
| training | output | 1 | Training or recovery in progress |
| train_fail | output | 1 | Sticky training failure |

## Verification
The assertions take `sup_mask` as constant outside reset. A rate picked under one mask and checked against another would trip the mask-membership property. The stimulus therefore draws a new mask only while reset is held, once per episode. The assertions also take `rx_rate` and `sym_lock` to be meaningful only as the stated conditions use them. The stimulus is free to present invalid codes 5 to 7 and lock at mismatched rates, which the controller must ignore. Rare pulses of abort, restart, recovery and manual mode drive every state, and short lock windows keep timeouts frequent.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int NUM_RATES = 5;
  localparam int RATE_W    = 3;

  typedef logic [RATE_W-1:0]    rate_t;
  typedef logic [NUM_RATES-1:0] rmask_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TRAIN, ST_LINKED, ST_RECOV, ST_FAILED, ST_MANUAL
  } lstate_e;

  typedef struct packed {
    logic  ok;
    rate_t idx;
  } pick_t;

  // highest supported code
  function automatic pick_t pick_top(rmask_t m);
    pick_t p;
    p.ok  = 1'b0;
    p.idx = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (m[i]) begin
        p.ok  = 1'b1;
        p.idx = rate_t'(i);
      end
    end
    return p;
  endfunction

  // highest supported code strictly below cur
  function automatic pick_t pick_below(rmask_t m, rate_t cur);
    pick_t p;
    p.ok  = 1'b0;
    p.idx = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (m[i] && (i < int'(cur))) begin
        p.ok  = 1'b1;
        p.idx = rate_t'(i);
      end
    end
    return p;
  endfunction

  // code r is a supported rate
  function automatic logic rate_legal(rmask_t m, rate_t r);
    logic ok;
    ok = 1'b0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (m[i] && (int'(r) == i)) ok = 1'b1;
    end
    return ok;
  endfunction
endpackage

// File: rtl/rfc_rate_pick.sv
module rfc_rate_pick
  import rfc_pkg::*;
(
  input  rmask_t mask,
  input  rate_t  cur,
  output pick_t  top,
  output pick_t  below
);
  always_comb begin
    top   = pick_top(mask);
    below = pick_below(mask, cur);
  end
endmodule

// File: rtl/rfc_lock_timer.sv
module rfc_lock_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;

  assign expired = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (clear || expired) cnt <= '0;
    else if (run)              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfc_link_seq.sv
module rfc_link_seq
  import rfc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  rmask_t  mask,
  input  logic    auto_en,
  input  rate_t   sw_rate,
  input  logic    sw_abort,
  input  logic    sw_restart,
  input  logic    rx_vld,
  input  rate_t   rx_rate,
  input  logic    sym_lock,
  input  logic    err_recov,
  input  logic    expired,
  input  pick_t   top,
  input  pick_t   below,
  output rate_t   tx_rate,
  output lstate_e state,
  output logic    fail,
  output logic    done,
  output logic    timer_clr,
  output logic    timer_run,
  output logic    ev_step,
  output logic    ev_lock
);
  lstate_e nxt_state;
  rate_t   nxt_rate;
  logic    nxt_fail;

  always_comb begin
    nxt_state = state;
    nxt_rate  = tx_rate;
    nxt_fail  = fail;
    ev_step   = 1'b0;
    ev_lock   = 1'b0;
    if (!auto_en) begin
      nxt_state = ST_MANUAL;
      if (rate_legal(mask, sw_rate)) nxt_rate = sw_rate;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (top.ok) begin
            nxt_state = ST_TRAIN;
            nxt_rate  = top.idx;
          end else begin
            nxt_state = ST_FAILED;
            nxt_fail  = 1'b1;
          end
        end
        ST_TRAIN: begin
          if (sw_abort) begin
            nxt_state = ST_FAILED;
            nxt_fail  = 1'b1;
          end else if (sym_lock && rx_vld && (rx_rate == tx_rate)) begin
            nxt_state = ST_LINKED;
            ev_lock   = 1'b1;
          end else if ((rx_vld && (rx_rate < tx_rate)) || expired) begin
            ev_step = 1'b1;
            if (below.ok) nxt_rate = below.idx;
            else begin
              nxt_state = ST_FAILED;
              nxt_fail  = 1'b1;
            end
          end
        end
        ST_LINKED: begin
          if (err_recov) nxt_state = ST_RECOV;
        end
        ST_RECOV: begin
          if (sw_abort) begin
            nxt_state = ST_FAILED;
            nxt_fail  = 1'b1;
          end else if (sym_lock) begin
            nxt_state = ST_LINKED;
            ev_lock   = 1'b1;
          end else if (expired) begin
            ev_step = 1'b1;
            if (below.ok) begin
              nxt_state = ST_TRAIN;
              nxt_rate  = below.idx;
            end else begin
              nxt_state = ST_FAILED;
              nxt_fail  = 1'b1;
            end
          end
        end
        ST_FAILED: begin
          if (sw_restart) begin
            nxt_state = ST_IDLE;
            nxt_fail  = 1'b0;
          end
        end
        default: nxt_state = ST_IDLE;
      endcase
    end
  end

  assign timer_run = (state == ST_TRAIN) || (state == ST_RECOV);
  assign timer_clr = ev_step || (nxt_state != state);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tx_rate <= '0;
      fail    <= 1'b0;
      done    <= 1'b0;
    end else begin
      state   <= nxt_state;
      tx_rate <= nxt_rate;
      fail    <= nxt_fail;
      done    <= (nxt_rate != tx_rate);
    end
  end
endmodule

// File: rtl/rate_fallback_ctrl.sv
module rate_fallback_ctrl
  import rfc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RATES-1:0] sup_mask,
  input  logic                 auto_en,
  input  logic [RATE_W-1:0]    sw_rate,
  input  logic                 sw_abort,
  input  logic                 sw_restart,
  input  logic                 rx_rate_vld,
  input  logic [RATE_W-1:0]    rx_rate,
  input  logic                 sym_lock,
  input  logic                 err_recov,
  input  logic [CNT_W-1:0]     lock_limit,
  output logic [RATE_W-1:0]    tx_rate,
  output logic                 rate_chg_done,
  output logic                 link_up,
  output logic                 training,
  output logic                 train_fail
);
  pick_t   top_pick, below_pick;
  lstate_e state;
  logic    expired, timer_clr, timer_run;
  logic    ev_step, ev_lock;

  rfc_rate_pick u_pick (
    .mask  (sup_mask),
    .cur   (tx_rate),
    .top   (top_pick),
    .below (below_pick)
  );

  rfc_lock_timer #(.CW(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (timer_clr),
    .run     (timer_run),
    .limit   (lock_limit),
    .expired (expired)
  );

  rfc_link_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask       (sup_mask),
    .auto_en    (auto_en),
    .sw_rate    (sw_rate),
    .sw_abort   (sw_abort),
    .sw_restart (sw_restart),
    .rx_vld     (rx_rate_vld),
    .rx_rate    (rx_rate),
    .sym_lock   (sym_lock),
    .err_recov  (err_recov),
    .expired    (expired),
    .top        (top_pick),
    .below      (below_pick),
    .tx_rate    (tx_rate),
    .state      (state),
    .fail       (train_fail),
    .done       (rate_chg_done),
    .timer_clr  (timer_clr),
    .timer_run  (timer_run),
    .ev_step    (ev_step),
    .ev_lock    (ev_lock)
  );

  assign link_up  = (state == ST_LINKED);
  assign training = (state == ST_TRAIN) || (state == ST_RECOV);
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker
  import rfc_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_RATES-1:0] sup_mask,
  input logic                 auto_en,
  input logic [RATE_W-1:0]    sw_rate,
  input logic                 sw_restart,
  input logic                 err_recov,
  input logic [RATE_W-1:0]    tx_rate,
  input logic                 rate_chg_done,
  input logic                 link_up,
  input logic                 training,
  input logic                 train_fail,
  input logic                 ev_step,
  input logic                 ev_lock
);
  AST_DONE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rate_chg_done |-> (tx_rate != $past(tx_rate))); // R12
  AST_RATE_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    rate_chg_done |-> rate_legal(sup_mask, tx_rate)); // R13
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({link_up, training})); // R7
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (train_fail && !sw_restart) |=> train_fail); // R6
  AST_LOCK_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock |=> link_up); // R4
  AST_STEP_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> ((tx_rate < $past(tx_rate)) || train_fail)); // R3
  AST_RECOV_SAME_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && err_recov && auto_en) |=> (training && $stable(tx_rate))); // R7
  AST_MANUAL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && rate_legal(sup_mask, sw_rate)) |=> (tx_rate == $past(sw_rate))); // R11
endmodule

bind rate_fallback_ctrl rfc_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sup_mask      (sup_mask),
  .auto_en       (auto_en),
  .sw_rate       (sw_rate),
  .sw_restart    (sw_restart),
  .err_recov     (err_recov),
  .tx_rate       (tx_rate),
  .rate_chg_done (rate_chg_done),
  .link_up       (link_up),
  .training      (training),
  .train_fail    (train_fail),
  .ev_step       (ev_step),
  .ev_lock       (ev_lock)
);

// File: tb/rate_fallback_ctrl_bench.sv
module rate_fallback_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  sup_mask = '0;
  logic        auto_en = 1'b1;
  logic [2:0]  sw_rate = '0;
  logic        sw_abort = 1'b0;
  logic        sw_restart = 1'b0;
  logic        rx_rate_vld = 1'b0;
  logic [2:0]  rx_rate = '0;
  logic        sym_lock = 1'b0;
  logic        err_recov = 1'b0;
  logic [15:0] lock_limit = 16'd3;
  logic [2:0]  tx_rate;
  logic        rate_chg_done, link_up, training, train_fail;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rate_fallback_ctrl u_rate_fallback_ctrl (
    .clk(clk), .rst_n(rst_n), .sup_mask(sup_mask), .auto_en(auto_en),
    .sw_rate(sw_rate), .sw_abort(sw_abort), .sw_restart(sw_restart),
    .rx_rate_vld(rx_rate_vld), .rx_rate(rx_rate), .sym_lock(sym_lock),
    .err_recov(err_recov), .lock_limit(lock_limit), .tx_rate(tx_rate),
    .rate_chg_done(rate_chg_done), .link_up(link_up), .training(training),
    .train_fail(train_fail)
  );

  // reference model, written from the requirements
  localparam int M_IDLE = 0, M_TRAIN = 1, M_LINK = 2, M_RECOV = 3, M_FAIL = 4, M_MAN = 5;
  int m_st = M_IDLE, m_rate = 0, m_cnt = 0;
  bit m_fail = 0, m_done = 0;

  function automatic int m_highest(logic [4:0] m);
    int r = 4;
    while (r >= 0 && !m[r]) r--;
    return r;
  endfunction

  function automatic int m_next_below(logic [4:0] m, int cur);
    int r = cur - 1;
    while (r >= 0 && !m[r]) r--;
    return r;
  endfunction

  always @(posedge clk) begin
    int ns, nr, nc, lo;
    bit nf, timeout;
    if (!rst_n) begin
      m_st = M_IDLE; m_rate = 0; m_cnt = 0; m_fail = 0; m_done = 0;
    end else begin
      ns = m_st; nr = m_rate; nf = m_fail; nc = m_cnt;
      timeout = (m_cnt >= int'(lock_limit));
      if (!auto_en) begin
        ns = M_MAN;
        if (sw_rate <= 3'd4 && sup_mask[sw_rate]) nr = int'(sw_rate);
      end else if (m_st == M_IDLE) begin
        lo = m_highest(sup_mask);
        if (lo < 0) begin ns = M_FAIL; nf = 1; end
        else begin ns = M_TRAIN; nr = lo; end
      end else if (m_st == M_TRAIN || m_st == M_RECOV) begin
        if (sw_abort) begin ns = M_FAIL; nf = 1; end
        else if (m_st == M_TRAIN && sym_lock && rx_rate_vld && int'(rx_rate) == m_rate) ns = M_LINK;
        else if (m_st == M_RECOV && sym_lock) ns = M_LINK;
        else if ((m_st == M_TRAIN && rx_rate_vld && int'(rx_rate) < m_rate) || timeout) begin
          lo = m_next_below(sup_mask, m_rate);
          nc = -1;
          if (lo < 0) begin ns = M_FAIL; nf = 1; end
          else begin ns = M_TRAIN; nr = lo; end
        end else nc = m_cnt + 1;
      end else if (m_st == M_LINK) begin
        if (err_recov) ns = M_RECOV;
      end else if (m_st == M_FAIL) begin
        if (sw_restart) begin ns = M_IDLE; nf = 0; end
      end else ns = M_IDLE;
      if (ns != m_st || nc < 0) nc = 0;
      if (!(ns == M_TRAIN || ns == M_RECOV)) nc = 0;
      m_done = (nr != m_rate);
      m_st = ns; m_rate = nr; m_fail = nf; m_cnt = nc;
    end
  end

  task automatic chk(int got, int exp, string req, string what);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic model_cmp();
    chk(int'(tx_rate), m_rate, "R13", "tx_rate");
    chk(int'(rate_chg_done), int'(m_done), "R12", "rate_chg_done");
    chk(int'(link_up), int'(m_st == M_LINK), "R4", "link_up");
    chk(int'(training), int'(m_st == M_TRAIN || m_st == M_RECOV), "R3", "training");
    chk(int'(train_fail), int'(m_fail), "R6", "train_fail");
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_cmp();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    sup_mask = 5'b10110;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(int'(tx_rate), 0, "R1", "reset tx_rate");
    chk(int'({rate_chg_done, link_up, training, train_fail}), 0, "R1", "reset status");
    rst_n = 1'b1;
    tick();
    chk(int'(tx_rate), 4, "R2", "start at top");
    chk(int'(training), 1, "R2", "training");
    chk(int'(rate_chg_done), 1, "R12", "done on start");
    tick();
    chk(int'(rate_chg_done), 0, "R12", "done one cycle");
    rx_rate_vld = 1; rx_rate = 3'd2;
    tick();
    chk(int'(tx_rate), 2, "R3", "skip unsupported code 3");
    sym_lock = 1;
    tick();
    chk(int'(link_up), 1, "R4", "link at common rate");
    chk(int'(tx_rate), 2, "R4", "rate held");
    sym_lock = 0; rx_rate_vld = 0; err_recov = 1;
    tick();
    err_recov = 0;
    chk(int'(training), 1, "R7", "recovery entered");
    chk(int'(tx_rate), 2, "R7", "recovery same rate");
    repeat (3) tick();
    chk(int'(tx_rate), 2, "R8", "still at rate in window");
    tick();
    chk(int'(tx_rate), 1, "R8", "recovery timeout step");
    repeat (3) tick();
    chk(int'(tx_rate), 1, "R5", "held for window");
    tick();
    chk(int'(train_fail), 1, "R6", "no lower rate");
    chk(int'(training), 0, "R6", "training stopped");
    chk(int'(tx_rate), 1, "R6", "rate kept");
    sw_restart = 1;
    tick();
    sw_restart = 0;
    chk(int'(train_fail), 0, "R10", "restart clears");
    tick();
    chk(int'(tx_rate), 4, "R10", "retrain from top");
    sw_abort = 1;
    tick();
    sw_abort = 0;
    chk(int'(train_fail), 1, "R9", "abort fails");
    chk(int'(training), 0, "R9", "abort stops");
    auto_en = 0; sw_rate = 3'd3;
    tick();
    chk(int'(tx_rate), 4, "R11", "unsupported sw rate ignored");
    sw_rate = 3'd2;
    tick();
    chk(int'(tx_rate), 2, "R11", "sw rate applied");
    chk(int'(rate_chg_done), 1, "R12", "done on manual change");
    sw_restart = 1;
    tick();
    sw_restart = 0;
    chk(int'(train_fail), 1, "R10", "restart ignored outside failed");
    auto_en = 1;

    // random episodes
    for (int ep = 0; ep < 12; ep++) begin
      rst_n = 0;
      sup_mask = (ep == 5) ? 5'b0 : 5'($urandom);
      lock_limit = 16'($urandom % 6);
      tick(); tick();
      rst_n = 1;
      for (int c = 0; c < 400; c++) begin
        auto_en     = ($urandom % 60) != 0;
        sw_rate     = 3'($urandom);
        rx_rate_vld = ($urandom % 4) != 0;
        rx_rate     = (($urandom % 3) == 0) ? 3'($urandom) : tx_rate;
        sym_lock    = ($urandom % 3) == 0;
        err_recov   = ($urandom % 30) == 0;
        sw_abort    = ($urandom % 150) == 0;
        sw_restart  = ($urandom % 15) == 0;
        tick();
      end
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule